// File: doc/BRIEF.md
# Slot-Skipping Packet Transmitter

This block moves one variable-length packet from a byte FIFO onto a shared byte-wide backplane whose time slots are split between circuit traffic and packet traffic. After the arbiter has granted the bus, the transmitter sends a start character and then the payload. It follows with an end character. Each of these goes into the next time slot that the slot qualifier reports as free for packets. Slots held by circuit connections are passed over and hold no state, so the packet simply stretches across however many slots it takes.

A slot that lines up with frame synchronisation is always treated as free, so packet traffic keeps a minimum share of the bus even if every other slot is reserved. If the FIFO has no byte ready when a free slot arrives in the middle of a packet, a null control character fills that slot. The packet keeps going and is not abandoned. Every sourced slot carries odd parity over the byte and its control flag. Once the end character has gone out, the drivers are released and a one-cycle done pulse is raised.

The qualifier's availability and frame-sync flags presented in one clock describe the slot that the transmitter drives in the following clock. The bus outputs are registered, and the FIFO read strobe is combinational for a first-word-fall-through FIFO.

Top module: `sstx_packet_tx`

## Requirements
- R1: A slot is sourced only when, one clock earlier, `slot_free` or `slot_sync` was high. In any other slot `bus_oe` is low and `bus_data`, `bus_ctrl` and `bus_par` are all 0.
- R2: During a packet, a slot announced with `slot_sync` high is always sourced, even if `slot_free` is low.
- R3: From idle, with `grant` high and the FIFO not empty, the first available slot carries the start character: `bus_data` = 0x01 and `bus_ctrl` = 1.
- R4: Payload bytes go out in FIFO order with `bus_ctrl` = 0. `fifo_rd` is high for exactly the clocks in which a byte is taken, and the byte appears on the bus in the next clock.
- R5: If the FIFO is empty when an available slot comes up after the start character and before the last byte, the slot carries the null character (`bus_data` = 0x00, `bus_ctrl` = 1). No byte is read, and the packet resumes with the next FIFO byte.
- R6: After the byte read with `fifo_last` = 1, the next available slot carries the end character: `bus_data` = 0x02 and `bus_ctrl` = 1.
- R7: In every sourced slot, `bus_par` makes the count of ones over `bus_data`, `bus_ctrl` and `bus_par` odd.
- R8: In the clock after the end-character slot, `bus_oe` is low and `done` is high for exactly one clock. The block then returns to idle.
- R9: After reset, and while idle without `grant`, the block drives nothing, reads nothing and keeps `done` low, even if the FIFO holds data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one byte slot per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| grant | input | 1 | Bus mastership from the arbiter |
| slot_free | input | 1 | Next slot is not reserved for circuit traffic |
| slot_sync | input | 1 | Next slot coincides with frame sync |
| fifo_data | input | DATA_W | FIFO head byte (first-word fall-through) |
| fifo_empty | input | 1 | FIFO has no byte ready |
| fifo_last | input | 1 | Head byte is the last of the packet |
| fifo_rd | output | 1 | Pops the FIFO head at this clock edge |
| bus_data | output | DATA_W | Byte driven into the slot |
| bus_ctrl | output | 1 | High for start, end and null characters |
| bus_par | output | 1 | Odd parity over byte and control flag |
| bus_oe | output | 1 | Drive enable for the byte, control and parity lines |
| done | output | 1 | One-cycle pulse after the packet has ended |

## Verification
The bench applies the slot flags, grant and FIFO state before a clock edge. It checks `fifo_rd` right away in that same cycle, since the strobe is combinational. It checks the slot contents one edge later, at the following falling edge, because the bus lines are registered. The done pulse is due one edge after the end-character slot, and the bench expects it in that same comparison window. The behavioural model steps in lockstep with these edges, and every cycle's expectation carries the tag of the requirement that defines it.

// File: rtl/sstx_pkg.sv
// Shared types for the slot-skipping packet transmitter.
// Assumes one byte slot per clock.
package sstx_pkg;

    // Transmitter sequence phases
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_SOD  = 3'd1,
        PH_BODY = 3'd2,
        PH_EOD  = 3'd3,
        PH_REL  = 3'd4
    } tx_phase_t;

    // Which value a sourced slot carries
    typedef enum logic [1:0] {
        TS_DATA = 2'd0,
        TS_SOD  = 2'd1,
        TS_EOD  = 2'd2,
        TS_NULL = 2'd3
    } tok_sel_t;

endpackage

// File: rtl/sstx_slot_gate.sv
// Slot gate: decides whether the upcoming slot may carry packet bytes.
// Assumes the qualifier flags describe the slot driven in the next clock.
// Frame-sync slots are always usable, so packet traffic keeps a minimum share.
module sstx_slot_gate (
    input  logic slot_free,
    input  logic slot_sync,
    output logic slot_use
);

    // Combine qualifier availability with the sync override
    always_comb begin
        slot_use = slot_free | slot_sync;
    end

endmodule

// File: rtl/sstx_seq.sv
// Packet sequencer: walks start, payload/null fill, end and release.
// It uses only the usable slots and waits in its phase through the others.
// Assumes a first-word-fall-through FIFO; fifo_rd pops at the clock edge.
module sstx_seq
    import sstx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      grant,
    input  logic      slot_use,
    input  logic      fifo_empty,
    input  logic      fifo_last,
    output logic      fifo_rd,
    output logic      tok_valid,
    output tok_sel_t  tok_sel,
    output logic      done_set,
    output logic      busy,
    output tx_phase_t phase
);

    tx_phase_t phase_nx;

    // Next phase and slot token from the current phase and the slot state
    always_comb begin
        phase_nx  = phase;
        fifo_rd   = 1'b0;
        tok_valid = 1'b0;
        tok_sel   = TS_DATA;
        done_set  = 1'b0;
        case (phase)
            PH_IDLE: begin
                if (grant && !fifo_empty) phase_nx = PH_SOD;
            end
            PH_SOD: begin
                if (slot_use) begin
                    tok_valid = 1'b1;
                    tok_sel   = TS_SOD;
                    phase_nx  = PH_BODY;
                end
            end
            PH_BODY: begin
                if (slot_use) begin
                    tok_valid = 1'b1;
                    if (!fifo_empty) begin
                        tok_sel = TS_DATA;
                        fifo_rd = 1'b1;
                        if (fifo_last) phase_nx = PH_EOD;
                    end else begin
                        tok_sel = TS_NULL;
                    end
                end
            end
            PH_EOD: begin
                if (slot_use) begin
                    tok_valid = 1'b1;
                    tok_sel   = TS_EOD;
                    phase_nx  = PH_REL;
                end
            end
            PH_REL: begin
                done_set = 1'b1;
                phase_nx = PH_IDLE;
            end
            default: phase_nx = PH_IDLE;
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= phase_nx;
    end

    // Packet in progress: a slot token may be pending
    always_comb begin
        busy = (phase == PH_SOD) || (phase == PH_BODY) || (phase == PH_EOD);
    end

    // The FIFO is never read outside the payload phase
    AST_IDLE_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> !fifo_rd); // R9

    // Release always follows an end-character slot
    AST_REL_AFTER_EOD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EOD && slot_use) |=> (phase == PH_REL)); // R8

endmodule

// File: rtl/sstx_lane.sv
// Lane driver: registers the slot value, control flag, odd parity and
// drive enable. Drives zeros whenever it does not source the slot.
// Assumes the token for a slot is presented in the clock before that slot.
module sstx_lane
    import sstx_pkg::*;
#(
    parameter int                DATA_W    = 8,
    parameter logic [DATA_W-1:0] SOD_CODE  = 8'h01,
    parameter logic [DATA_W-1:0] EOD_CODE  = 8'h02,
    parameter logic [DATA_W-1:0] NULL_CODE = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_valid,
    input  tok_sel_t          tok_sel,
    input  logic [DATA_W-1:0] payload,
    input  logic              done_set,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_ctrl,
    output logic              bus_par,
    output logic              bus_oe,
    output logic              done
);

    logic [DATA_W-1:0] code;
    logic              is_ctrl;
    logic              par_odd;

    // Select the slot value and control flag for the pending token
    always_comb begin
        is_ctrl = 1'b1;
        case (tok_sel)
            TS_SOD:  code = SOD_CODE;
            TS_EOD:  code = EOD_CODE;
            TS_NULL: code = NULL_CODE;
            default: begin
                code    = payload;
                is_ctrl = 1'b0;
            end
        endcase
        par_odd = ~(^{code, is_ctrl});
    end

    // Slot output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_data <= '0;
            bus_ctrl <= 1'b0;
            bus_par  <= 1'b0;
            bus_oe   <= 1'b0;
            done     <= 1'b0;
        end else begin
            bus_oe <= tok_valid;
            done   <= done_set;
            if (tok_valid) begin
                bus_data <= code;
                bus_ctrl <= is_ctrl;
                bus_par  <= par_odd;
            end else begin
                bus_data <= '0;
                bus_ctrl <= 1'b0;
                bus_par  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sstx_packet_tx.sv
// Slot-skipping packet transmitter top.
// Chains the slot gate, the sequencer and the lane driver.
// Assumes grant comes from an external arbiter and the FIFO shows its head
// byte without a read latency.
module sstx_packet_tx
    import sstx_pkg::*;
#(
    parameter int                DATA_W    = 8,
    parameter logic [DATA_W-1:0] SOD_CODE  = 8'h01,
    parameter logic [DATA_W-1:0] EOD_CODE  = 8'h02,
    parameter logic [DATA_W-1:0] NULL_CODE = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant,
    input  logic              slot_free,
    input  logic              slot_sync,
    input  logic [DATA_W-1:0] fifo_data,
    input  logic              fifo_empty,
    input  logic              fifo_last,
    output logic              fifo_rd,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_ctrl,
    output logic              bus_par,
    output logic              bus_oe,
    output logic              done
);

    logic      slot_use;
    logic      tok_valid;
    tok_sel_t  tok_sel;
    logic      done_set;
    logic      busy;
    tx_phase_t phase;
    logic      started;

    sstx_slot_gate u_gate (
        .slot_free (slot_free),
        .slot_sync (slot_sync),
        .slot_use  (slot_use)
    );

    sstx_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .grant      (grant),
        .slot_use   (slot_use),
        .fifo_empty (fifo_empty),
        .fifo_last  (fifo_last),
        .fifo_rd    (fifo_rd),
        .tok_valid  (tok_valid),
        .tok_sel    (tok_sel),
        .done_set   (done_set),
        .busy       (busy),
        .phase      (phase)
    );

    sstx_lane #(
        .DATA_W    (DATA_W),
        .SOD_CODE  (SOD_CODE),
        .EOD_CODE  (EOD_CODE),
        .NULL_CODE (NULL_CODE)
    ) u_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .tok_valid (tok_valid),
        .tok_sel   (tok_sel),
        .payload   (fifo_data),
        .done_set  (done_set),
        .bus_data  (bus_data),
        .bus_ctrl  (bus_ctrl),
        .bus_par   (bus_par),
        .bus_oe    (bus_oe),
        .done      (done)
    );

    // Marks that one clean clock has passed since reset, so $past is valid
    always_ff @(posedge clk) begin
        if (!rst_n) started <= 1'b0;
        else        started <= 1'b1;
    end

    AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (started && !$past(slot_use)) |-> !bus_oe); // R1

    AST_SYNC_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (started && $past(slot_sync && busy)) |-> bus_oe); // R2

    AST_POP_IS_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (started && $past(fifo_rd)) |-> (bus_oe && !bus_ctrl && bus_data == $past(fifo_data))); // R4

    AST_NULL_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (started && $past(phase == PH_BODY && slot_use && fifo_empty)) |-> (bus_oe && bus_ctrl && bus_data == NULL_CODE)); // R5

    AST_ODD_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (^{bus_data, bus_ctrl, bus_par} == 1'b1)); // R7

    AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_oe); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

endmodule

// File: tb/test_sstx_packet_tx.sv
// Bench: drives slot flags, grant and a queue-backed FIFO, and compares every
// clock against a behavioural model of the slot stream.
module test_sstx_packet_tx;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       grant, slot_free, slot_sync;
    logic [7:0] fifo_data;
    logic       fifo_empty, fifo_last;
    logic       fifo_rd;
    logic [7:0] bus_data;
    logic       bus_ctrl, bus_par, bus_oe, done;

    always #5 clk = ~clk;

    sstx_packet_tx i_sstx_packet_tx (
        .clk(clk), .rst_n(rst_n), .grant(grant),
        .slot_free(slot_free), .slot_sync(slot_sync),
        .fifo_data(fifo_data), .fifo_empty(fifo_empty), .fifo_last(fifo_last),
        .fifo_rd(fifo_rd), .bus_data(bus_data), .bus_ctrl(bus_ctrl),
        .bus_par(bus_par), .bus_oe(bus_oe), .done(done)
    );

    int         n_run = 0;
    int         n_fail = 0;
    bit         finished = 0;
    int         m_ph = 0;           // 0 idle, 1 start, 2 payload, 3 end, 4 release
    logic       e_oe = 0, e_ctrl = 0, e_done = 0;
    logic [7:0] e_data = 0;
    string      e_tag = "R9";
    logic [8:0] q[$];               // {last, byte}

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic push_pkt(input int len, input int seed);
        for (int k = 0; k < len; k++)
            q.push_back({(k == len - 1), 8'((seed * 37 + k * 53 + 11) & 8'hff)});
    endtask

    task automatic step(input bit g, input bit fr, input bit sy, input bit hold);
        bit         slot, emp, rd_exp;
        string      rd_tag;
        @(negedge clk);
        // Compare the slot the design sourced after the previous edge
        chk(bus_oe == e_oe, e_tag, "bus_oe", bus_oe, e_oe);
        if (e_oe) begin
            chk(bus_data == e_data, e_tag, "bus_data", bus_data, e_data);
            chk(bus_ctrl == e_ctrl, e_tag, "bus_ctrl", bus_ctrl, e_ctrl);
            chk((^{bus_data, bus_ctrl, bus_par}) == 1'b1, "R7", "parity",
                {bus_data, bus_ctrl, bus_par}, {e_data, e_ctrl, ~(^{e_data, e_ctrl})});
        end else begin
            chk({bus_data, bus_ctrl, bus_par} == 10'd0, "R1", "idle lines",
                {bus_data, bus_ctrl, bus_par}, 0);
        end
        chk(done == e_done, e_done ? "R8" : e_tag, "done", done, e_done);
        // Apply this cycle's stimulus
        grant      = g;
        slot_free  = fr;
        slot_sync  = sy;
        fifo_empty = (q.size() == 0) || hold;
        fifo_data  = (q.size() != 0) ? q[0][7:0] : 8'h00;
        fifo_last  = (q.size() != 0) ? q[0][8] : 1'b0;
        #1;
        // Reference model for the slot after the coming edge
        slot = fr || sy;
        emp = fifo_empty;
        rd_exp = 0;
        rd_tag = "R4";
        e_oe = 0; e_ctrl = 0; e_data = 8'h00; e_done = 0;
        e_tag = slot ? "R2" : "R1";
        case (m_ph)
            0: begin
                e_tag = "R9"; rd_tag = "R9";
                if (g && !emp) m_ph = 1;
            end
            1: if (slot) begin
                e_oe = 1; e_ctrl = 1; e_data = 8'h01; e_tag = fr ? "R3" : "R2"; m_ph = 2;
            end
            2: if (slot) begin
                e_oe = 1;
                if (!emp) begin
                    e_ctrl = 0; e_data = fifo_data; rd_exp = 1;
                    e_tag = fr ? "R4" : "R2";
                    if (fifo_last) m_ph = 3;
                end else begin
                    e_ctrl = 1; e_data = 8'h00; e_tag = "R5";
                end
            end
            3: if (slot) begin
                e_oe = 1; e_ctrl = 1; e_data = 8'h02; e_tag = fr ? "R6" : "R2"; m_ph = 4;
            end
            default: begin
                e_done = 1; e_tag = "R8"; m_ph = 0;
            end
        endcase
        chk(fifo_rd == rd_exp, rd_tag, "fifo_rd", fifo_rd, rd_exp);
        @(posedge clk);
        #1;
        if (rd_exp) void'(q.pop_front());
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; grant = 0; slot_free = 0; slot_sync = 0;
        fifo_data = 0; fifo_empty = 1; fifo_last = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R9: reset state, then data waiting without grant is left alone
        push_pkt(4, 1);
        for (int i = 0; i < 5; i++) step(0, 1, (i == 2), 0);
        // R3 R4 R6 R8: all slots free
        for (int i = 0; i < 12; i++) step(1, 1, 0, 0);
        for (int i = 0; i < 3; i++) step(0, 1, 0, 0);
        // R1 R2: circuit slots interleaved, some sync-only slots
        push_pkt(6, 2);
        for (int i = 0; i < 30; i++) step(1, (i % 3 == 1), (i % 7 == 3), 0);
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0);
        // R5: underrun in the middle of a packet
        push_pkt(5, 3);
        for (int i = 0; i < 20; i++) step(1, (i % 2 == 0) || (i > 10), 0, (i >= 4 && i < 9));
        for (int i = 0; i < 3; i++) step(0, 1, 0, 0);
        // R2: every slot reserved, only sync slots carry the packet
        push_pkt(3, 4);
        for (int i = 0; i < 30; i++) step(1, 0, (i % 4 == 0), 0);
        // Single-byte packet with skipped slots around the end character
        push_pkt(1, 5);
        for (int i = 0; i < 12; i++) step(1, (i % 2 == 1), 0, 0);
        for (int i = 0; i < 4; i++) step(0, 1, 1, 0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule